// File: doc/BRIEF.md
# Branch Target Address Cache

This block records the target addresses of taken branches in a set-associative store. For every taken branch the pipeline presents the target address with a one-cycle valid strobe. The block searches the set chosen by the low address bits, compares the full stored address of each way, and reports hit or miss together with the way that was used. On a miss, the address is installed into a victim way and the instruction word cached alongside that way is invalidated.

Replacement is driven by a small usage counter per way. On every lookup the counters in the addressed set decay toward zero and the way just used is set to the top of its range. The victim on a miss is the highest-numbered way whose counter is below the top value, or way 0 if no way qualifies. Two free-running statistics counters count hits and misses. Each way also holds a one-block instruction word (4 bytes by default) with its own valid bit. The block only clears this word; it never fills it.

Top module: `btac_top`

## Requirements
- R1: After a synchronous reset, `rsp_valid` is 0, both statistics counters read 0, and no stored address is valid, so the first lookup of any address misses.
- R2: A lookup presented with `req_valid` high in one cycle produces `rsp_valid` high after the next rising edge, and no other response appears. Cycles with `req_valid` low change no state and produce `rsp_valid` low.
- R3: The set is `req_addr` modulo `SETS`, which is the low log2(`SETS`) bits. Addresses that share these bits compete for the same ways, and lookups in other sets leave them alone.
- R4: A lookup hits only when a way of the indexed set holds a valid address equal to all `AW` bits of `req_addr`.
- R5: `hit_count` increments by 1 on every hit response and `miss_count` by 1 on every miss response. Both wrap modulo 2^`CW` and hold otherwise.
- R6: On every lookup, each nonzero usage counter of the indexed set decrements by 1, and the used way's counter is then set to `USTATES`-1. The used way is the matching way on a hit and the victim on a miss.
- R7: On a miss, the victim is the highest-numbered way whose usage counter is below `USTATES`-1, or way 0 if there is none. `rsp_way` reports the matching way on a hit and the victim way on a miss.
- R8: Installing an address replaces the victim's previous address, so a later lookup of the evicted address misses.
- R9: Installing an address invalidates the victim's instruction word. Any response for an installed way therefore shows `rsp_blk_valid` = 0 and `rsp_blk` = 0.
- R10: A lookup of the same address on two consecutive cycles always hits the second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe, one lookup per cycle |
| req_addr | input | AW | Branch target address to look up |
| rsp_valid | output | 1 | Registered response valid |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | log2(WAYS) | Way matched or way installed |
| rsp_blk_valid | output | 1 | Valid bit of that way's instruction word |
| rsp_blk | output | BLK_BYTES*8 | That way's instruction word |
| hit_count | output | CW | Hit statistics counter |
| miss_count | output | CW | Miss statistics counter |

## Verification
The hardest behaviour to reach is a victim choice that depends on usage history rather than on the order of installs. A way must be protected by a recent hit while its partner's counter has decayed. The stimulus does this with directed lookups that alias through the set index: it fills one set, hits one way, and then forces a miss. After that, a long stream of lookups drawn from a small pool of aliasing addresses, mixed with idle cycles, is compared on every clock against a behavioural model of sets, ways and counters.

// File: rtl/btac_pkg.sv
package btac_pkg;

  // Width of a usage counter holding 0 .. n-1
  function automatic int use_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Width of an index selecting one of n items
  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/btac_way_store.sv
module btac_way_store #(
  parameter int AW       = 32,
  parameter int SETS     = 128,
  parameter int UW       = 1,
  parameter int BLK_BITS = 32,
  localparam int IW      = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IW-1:0]       rd_set,
  output logic [AW-1:0]       rd_tag,
  output logic                rd_tag_vld,
  output logic [UW-1:0]       rd_use,
  output logic                rd_blk_vld,
  output logic [BLK_BITS-1:0] rd_blk,
  input  logic                upd_en,
  input  logic [IW-1:0]       upd_set,
  input  logic                upd_install,
  input  logic [AW-1:0]       upd_tag,
  input  logic [UW-1:0]       upd_use
);

  logic [AW-1:0]       tag_mem [SETS];
  logic [BLK_BITS-1:0] blk_mem [SETS];
  logic [UW-1:0]       use_mem [SETS];
  logic [SETS-1:0]     tag_vld;
  logic [SETS-1:0]     blk_vld;

  // Address and data words: no reset, plain write port
  always_ff @(posedge clk) begin
    if (upd_en && upd_install) begin
      tag_mem[upd_set] <= upd_tag;
      blk_mem[upd_set] <= '0;
    end
  end

  // Valid bits and usage counters: reset to empty
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_vld <= '0;
      blk_vld <= '0;
      for (int s = 0; s < SETS; s++) use_mem[s] <= '0;
    end else if (upd_en) begin
      use_mem[upd_set] <= upd_use;
      if (upd_install) begin
        tag_vld[upd_set] <= 1'b1;
        blk_vld[upd_set] <= 1'b0;
      end
    end
  end

  assign rd_tag     = tag_mem[rd_set];
  assign rd_tag_vld = tag_vld[rd_set];
  assign rd_use     = use_mem[rd_set];
  assign rd_blk_vld = blk_vld[rd_set];
  assign rd_blk     = blk_mem[rd_set];

endmodule

// File: rtl/btac_victim.sv
module btac_victim #(
  parameter int WAYS = 2,
  parameter int UW   = 1,
  parameter int WW   = 1,
  parameter logic [UW-1:0] UMAX = '1
) (
  input  logic [WAYS*UW-1:0] use_flat,
  output logic [WW-1:0]      victim
);

  // Highest-numbered way whose usage is below the top value, else way 0
  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (use_flat[w*UW +: UW] < UMAX) victim = WW'(w);
    end
  end

endmodule

// File: rtl/btac_stats.sv
module btac_stats #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_valid,
  input  logic          evt_hit,
  output logic [CW-1:0] hit_cnt,
  output logic [CW-1:0] miss_cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (evt_valid) begin
      if (evt_hit) hit_cnt  <= hit_cnt  + CW'(1);
      else         miss_cnt <= miss_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/btac_top.sv
module btac_top #(
  parameter int AW        = 32,
  parameter int SETS      = 128,
  parameter int WAYS      = 2,
  parameter int USTATES   = 2,
  parameter int BLK_BYTES = 4,
  parameter int CW        = 32,
  localparam int IW       = $clog2(SETS),
  localparam int WW       = btac_pkg::idx_width(WAYS),
  localparam int UW       = btac_pkg::use_width(USTATES),
  localparam int BLK_BITS = BLK_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [WW-1:0]       rsp_way,
  output logic                rsp_blk_valid,
  output logic [BLK_BITS-1:0] rsp_blk,
  output logic [CW-1:0]       hit_count,
  output logic [CW-1:0]       miss_count
);

  localparam logic [UW-1:0] UMAX = UW'(USTATES - 1);

  logic [IW-1:0]       set_idx;
  logic [AW-1:0]       way_tag  [WAYS];
  logic [BLK_BITS-1:0] way_blk  [WAYS];
  logic [UW-1:0]       use_next [WAYS];
  logic [WAYS-1:0]     way_vld;
  logic [WAYS-1:0]     way_bvld;
  logic [WAYS*UW-1:0]  use_flat;
  logic [WW-1:0]       victim;
  logic [WW-1:0]       hit_way;
  logic [WW-1:0]       used_way;
  logic                hit;

  assign set_idx = req_addr[IW-1:0];

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      btac_way_store #(
        .AW(AW), .SETS(SETS), .UW(UW), .BLK_BITS(BLK_BITS)
      ) store_i (
        .clk         (clk),
        .rst         (rst),
        .rd_set      (set_idx),
        .rd_tag      (way_tag[g]),
        .rd_tag_vld  (way_vld[g]),
        .rd_use      (use_flat[g*UW +: UW]),
        .rd_blk_vld  (way_bvld[g]),
        .rd_blk      (way_blk[g]),
        .upd_en      (req_valid),
        .upd_set     (set_idx),
        .upd_install (req_valid && !hit && (victim == WW'(g))),
        .upd_tag     (req_addr),
        .upd_use     (use_next[g])
      );
    end
  endgenerate

  // Full-address compare across the ways of the set
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_vld[w] && (way_tag[w] == req_addr)) begin
        hit     = 1'b1;
        hit_way = WW'(w);
      end
    end
  end

  btac_victim #(
    .WAYS(WAYS), .UW(UW), .WW(WW), .UMAX(UMAX)
  ) victim_i (
    .use_flat (use_flat),
    .victim   (victim)
  );

  assign used_way = hit ? hit_way : victim;

  // Usage decay with refresh of the used way
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WW'(w) == used_way)
        use_next[w] = UMAX;
      else if (use_flat[w*UW +: UW] != '0)
        use_next[w] = use_flat[w*UW +: UW] - UW'(1);
      else
        use_next[w] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      rsp_blk_valid <= 1'b0;
      rsp_blk       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit       <= hit;
        rsp_way       <= used_way;
        rsp_blk_valid <= hit ? way_bvld[hit_way] : 1'b0;
        rsp_blk       <= hit ? way_blk[hit_way] : '0;
      end
    end
  end

  btac_stats #(.CW(CW)) stats_i (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (req_valid),
    .evt_hit   (hit),
    .hit_cnt   (hit_count),
    .miss_cnt  (miss_count)
  );

endmodule

// File: rtl/btac_checker.sv
module btac_checker #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [CW-1:0] hit_count,
  input logic [CW-1:0] miss_count
);

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_hit_step_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (hit_count == CW'($past(hit_count) + CW'(1))));

  p_miss_step_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (miss_count == CW'($past(miss_count) + CW'(1))));

  p_stats_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ($stable(hit_count) && $stable(miss_count)));

  p_repeat_hits_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid) && !$past(rst) && (req_addr == $past(req_addr)))
    |=> rsp_hit);

endmodule

bind btac_top btac_checker #(.AW(AW), .CW(CW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/btac_top_tb_top.sv
`timescale 1ns/1ps
module btac_top_tb_top;

  localparam int NSETS = 128;
  localparam int NWAYS = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_blk_valid;
  logic [0:0]  rsp_way;
  logic [31:0] rsp_blk, hit_count, miss_count;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [31:0] m_tag [NSETS][NWAYS];
  bit          m_vld [NSETS][NWAYS];
  int          m_use [NSETS][NWAYS];
  int          m_hits = 0;
  int          m_miss = 0;
  bit          e_valid, e_hit;
  int          e_way;

  always #5 clk = ~clk;

  btac_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_blk_valid(rsp_blk_valid), .rsp_blk(rsp_blk),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        m_vld[s][w] = 0; m_use[s][w] = 0; m_tag[s][w] = '0;
      end
    m_hits = 0; m_miss = 0;
  endtask

  task automatic model_access(input logic [31:0] a);
    int s, used;
    s = int'(a % NSETS);
    e_hit = 0; used = 0;
    for (int w = 0; w < NWAYS; w++)
      if (m_vld[s][w] && m_tag[s][w] == a) begin e_hit = 1; used = w; end
    if (!e_hit) begin
      used = 0;
      for (int w = 0; w < NWAYS; w++) if (m_use[s][w] < 1) used = w;
      m_tag[s][used] = a; m_vld[s][used] = 1;
      m_miss++;
    end else m_hits++;
    for (int w = 0; w < NWAYS; w++) if (m_use[s][w] > 0) m_use[s][w]--;
    m_use[s][used] = 1;
    e_way = used;
  endtask

  task automatic access(input bit v, input logic [31:0] a);
    @(negedge clk);
    req_valid = v;
    req_addr  = a;
    e_valid   = v;
    if (v) model_access(a);
    @(posedge clk);
    #1;
    check(rsp_valid == e_valid, "R2", "rsp_valid", rsp_valid, e_valid);
    if (e_valid) begin
      check(rsp_hit == e_hit, "R4", "rsp_hit", rsp_hit, e_hit);
      check(rsp_way == 1'(e_way), "R7", "rsp_way", rsp_way, e_way);
      check(rsp_blk_valid == 1'b0 && rsp_blk == '0, "R9", "instruction word",
            rsp_blk_valid, 0);
    end
    check(hit_count == 32'(m_hits), "R5", "hit_count", hit_count, m_hits);
    check(miss_count == 32'(m_miss), "R5", "miss_count", miss_count, m_miss);
  endtask

  // Explicit expectation on the last response
  task automatic expect_rsp(input bit hit, input int way, input string req);
    check(rsp_hit == hit, req, "directed hit", rsp_hit, hit);
    check(rsp_way == 1'(way), req, "directed way", rsp_way, way);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state at the ports
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(hit_count == '0, "R1", "hit_count after reset", hit_count, 0);
    check(miss_count == '0, "R1", "miss_count after reset", miss_count, 0);

    // R1/R7: first lookup misses, fresh set picks highest way
    access(1, 32'd10);          expect_rsp(0, 1, "R1");
    // R10: repeat hits
    access(1, 32'd10);          expect_rsp(1, 1, "R10");
    // R3: alias into same set, victim is way 0
    access(1, 32'd138);         expect_rsp(0, 0, "R3");
    // R6: hit refreshes way 1, way 0 decays
    access(1, 32'd10);          expect_rsp(1, 1, "R6");
    // R7: protected way 1, victim way 0 (evicts 138)
    access(1, 32'd266);         expect_rsp(0, 0, "R7");
    // R8: evicted address misses, now victim way 1 (evicts 10)
    access(1, 32'd138);         expect_rsp(0, 1, "R8");
    access(1, 32'd10);          expect_rsp(0, 0, "R8");
    // R4: upper bit differs only
    access(1, 32'h8000_000A);   expect_rsp(0, 1, "R4");
    // R3: a different set is untouched and fresh
    access(1, 32'd11);          expect_rsp(0, 1, "R3");
    // R2: idle cycles with moving address change nothing
    access(0, 32'd10);
    access(0, 32'd11);
    access(1, 32'd11);          expect_rsp(1, 1, "R2");

    // Mixed stream from a small aliasing pool, compared to the model
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      access(lfsr[0] | lfsr[1] | lfsr[2],
             {lfsr[12], 21'd0, lfsr[9:8], 1'b0, 5'd0, lfsr[5:4]} |
             (lfsr[7] ? 32'd128 : 32'd0));
    end

    // R1: reset mid-run clears contents and statistics
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_reset();
    #1;
    check(hit_count == '0 && miss_count == '0, "R1", "stats after re-reset",
          hit_count + miss_count, 0);
    access(1, 32'd11);          expect_rsp(0, 1, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule